// File: doc/BRIEF.md
# Flash Write Block Splitter

This controller sits in front of a per-block erase/program engine for a flash window that holds either 1 MiB or 4 MiB. It takes a write request, given as a byte offset and a byte count. The request is checked against two enable flags that a small command port sets and clears. The count is clipped so that it stops at the end of the device. The request is then cut into jobs, one for each 64 KiB block it touches. For each block the controller asks the engine for an erase and then a program. It does this over a start/done handshake with a pass/fail flag and a returned byte count.

A failed erase is retried on the same block. A failed program sends the block back to its erase. Each kind of attempt has its own limit, and exceeding it ends the request with an error code. At the end the controller gives a one-cycle done pulse, the total number of bytes the engine reported as written, and an error code. Data movement and buffer contents belong to the engine. The controller only supplies the block index, the device offset, the job length and the buffer index.

Top module: `blk_write_splitter`

## Requirements
- R1: Command codes act on the enable flags. Code 1 sets write-enable, code 2 sets low-region enable, and code 0 clears both flags. Code 3 clears both flags and raises cmd_err for exactly one cycle, in the cycle after the command.
- R2: When write-enable is clear, an accepted request finishes in the next cycle with done=1, err_code=1, bytes_written=0, and no engine job.
- R3: A request whose offset is below 65536 while low-region enable is clear finishes in the next cycle with err_code=2 and no engine job.
- R4: A request that passes both enable checks and has a zero count finishes in the next cycle with err_code=0, bytes_written=0, and no engine job.
- R5: The capacity is 1 MiB when size_sel=0 and 4 MiB when size_sel=1. A non-zero request whose offset is at or beyond the capacity finishes in the next cycle with err_code=3.
- R6: A count that runs past the capacity is clipped to (capacity - offset).
- R7: The first block index is offset>>16. The job count is ((offset+count)>>16) - (offset>>16) + 1, less one when (offset+count) has zero low 16 bits. Each block issues an erase (eng_op=0) before its program (eng_op=1), and the block index rises by one per finished block.
- R8: A job's eng_len is min(remaining bytes, 65536 - offset[15:0]). After a successful program, eng_off and eng_buf advance by eng_nbytes.
- R9: A failed erase is retried on the same block. Every erase completion in a block counts as an attempt. A failure on attempt 10 or later ends the request with err_code=4, and bytes_written holds the total from the blocks already finished.
- R10: A failed program (eng_ok=0) returns to that block's erase. A failure on the 10th program attempt in a block ends the request with err_code=5.
- R11: eng_start is a one-cycle pulse. It is never raised while a job is outstanding, and req_ready is low from acceptance until done.
- R12: done is a one-cycle pulse. With err_code=0 and a non-zero count, bytes_written equals the sum of eng_nbytes over all successful programs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 2 | 0 lock, 1 unlock, 2 unlock low region, 3 invalid |
| cmd_err | output | 1 | One-cycle pulse after an invalid command |
| size_sel | input | 1 | 0: 1 MiB device, 1: 4 MiB device |
| req_valid | input | 1 | Request strobe, taken when req_ready is high |
| req_ready | output | 1 | Controller idle |
| req_offset | input | OFF_W | Start byte offset |
| req_count | input | CNT_W | Byte count |
| eng_start | output | 1 | Engine job start pulse |
| eng_op | output | 1 | 0 erase, 1 program |
| eng_blk | output | OFF_W-16 | 64 KiB block index of the job |
| eng_off | output | OFF_W | Device byte offset of the job |
| eng_len | output | CNT_W | Bytes the job may write in this block |
| eng_buf | output | CNT_W | Buffer index (bytes already written) |
| eng_done | input | 1 | Engine job complete |
| eng_ok | input | 1 | Engine job passed |
| eng_nbytes | input | CNT_W | Bytes written by a passing program |
| done | output | 1 | Request finished pulse |
| bytes_written | output | CNT_W | Total bytes written, valid with done |
| err_code | output | 3 | 0 ok, 1 disabled, 2 protected, 3 range, 4 erase, 5 program |

## Verification
The hardest cases to reach are the retry limits. Erase attempts pile up across the program retries of one block, so a tenth failure can land on either operation. It matters which counter reaches its limit first. The bench plays the engine itself. It fails a chosen number of erases or programs on one chosen block of a multi-block request, so the run reaches each limit after earlier blocks have already added to the byte total. Requests that straddle a block edge and requests that end exactly on one exercise the job-count correction.

// File: rtl/bws_pkg.sv
package bws_pkg;
  typedef enum logic [2:0] {
    BWS_OK        = 3'd0,
    BWS_ERR_OFF   = 3'd1,
    BWS_ERR_PROT  = 3'd2,
    BWS_ERR_RANGE = 3'd3,
    BWS_ERR_ERASE = 3'd4,
    BWS_ERR_PROG  = 3'd5
  } bws_err_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ERASE_GO,
    S_ERASE_WAIT,
    S_PROG_GO,
    S_PROG_WAIT
  } bws_state_e;

  localparam logic [1:0] CMD_LOCK        = 2'd0;
  localparam logic [1:0] CMD_UNLOCK      = 2'd1;
  localparam logic [1:0] CMD_UNLOCK_BOOT = 2'd2;
endpackage

// File: rtl/bws_enable_regs.sv
module bws_enable_regs
  import bws_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_code,
  output logic       wr_en,
  output logic       low_en,
  output logic       cmd_err
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_en   <= 1'b0;
      low_en  <= 1'b0;
      cmd_err <= 1'b0;
    end else begin
      cmd_err <= 1'b0;
      if (cmd_valid) begin
        case (cmd_code)
          CMD_LOCK: begin
            wr_en  <= 1'b0;
            low_en <= 1'b0;
          end
          CMD_UNLOCK:      wr_en  <= 1'b1;
          CMD_UNLOCK_BOOT: low_en <= 1'b1;
          default: begin
            wr_en   <= 1'b0;
            low_en  <= 1'b0;
            cmd_err <= 1'b1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/bws_req_check.sv
module bws_req_check
  import bws_pkg::*;
#(
  parameter int OFF_W      = 24,
  parameter int CNT_W      = 24,
  parameter int BLK_SHIFT  = 16,
  parameter int SMALL_LOG2 = 20,
  parameter int LARGE_LOG2 = 22,
  parameter int BLK_W      = OFF_W - BLK_SHIFT,
  parameter int NBLK_W     = BLK_W + 1
) (
  input  logic              wr_en,
  input  logic              low_en,
  input  logic              size_sel,
  input  logic [OFF_W-1:0]  offset,
  input  logic [CNT_W-1:0]  count,
  output bws_err_e          chk_err,
  output logic              chk_zero,
  output logic [CNT_W-1:0]  clip_cnt,
  output logic [BLK_W-1:0]  first_blk,
  output logic [NBLK_W-1:0] n_blk
);
  localparam int SUM_W = ((OFF_W > CNT_W) ? OFF_W : CNT_W) + 1;
  localparam logic [SUM_W-1:0] ONE = SUM_W'(1);

  function automatic logic [SUM_W-1:0] f_cap(input logic big);
    return big ? (ONE << LARGE_LOG2) : (ONE << SMALL_LOG2);
  endfunction

  function automatic logic [SUM_W-1:0] f_clip(input logic [SUM_W-1:0] cap,
                                              input logic [SUM_W-1:0] off,
                                              input logic [SUM_W-1:0] cnt);
    logic [SUM_W-1:0] room;
    room = cap - off;
    return (cnt > room) ? room : cnt;
  endfunction

  function automatic logic [NBLK_W-1:0] f_nblk(input logic [SUM_W-1:0] off,
                                               input logic [SUM_W-1:0] cnt);
    logic [SUM_W-1:0] end_a;
    logic [SUM_W-1:0] n;
    end_a = off + cnt;
    n = (end_a >> BLK_SHIFT) - (off >> BLK_SHIFT) + ONE;
    if (end_a[BLK_SHIFT-1:0] == '0) n = n - ONE;
    return NBLK_W'(n);
  endfunction

  logic [SUM_W-1:0] off_x, cnt_x, cap_x, clip_x;

  always_comb begin
    off_x     = SUM_W'(offset);
    cnt_x     = SUM_W'(count);
    cap_x     = f_cap(size_sel);
    clip_x    = f_clip(cap_x, off_x, cnt_x);
    clip_cnt  = CNT_W'(clip_x);
    first_blk = BLK_W'(off_x >> BLK_SHIFT);
    n_blk     = f_nblk(off_x, clip_x);
    chk_zero  = (count == '0);
    if (!wr_en)
      chk_err = BWS_ERR_OFF;
    else if (off_x < (ONE << BLK_SHIFT) && !low_en)
      chk_err = BWS_ERR_PROT;
    else if (!chk_zero && off_x >= cap_x)
      chk_err = BWS_ERR_RANGE;
    else
      chk_err = BWS_OK;
  end
endmodule

// File: rtl/bws_seq.sv
module bws_seq
  import bws_pkg::*;
#(
  parameter int OFF_W     = 24,
  parameter int CNT_W     = 24,
  parameter int BLK_SHIFT = 16,
  parameter int MAX_TRIES = 10,
  parameter int BLK_W     = OFF_W - BLK_SHIFT,
  parameter int NBLK_W    = BLK_W + 1,
  parameter int TRY_W     = $clog2(MAX_TRIES + 1) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_job,
  input  logic              finish_now,
  input  bws_err_e          finish_err,
  input  logic [OFF_W-1:0]  ld_off,
  input  logic [CNT_W-1:0]  ld_cnt,
  input  logic [BLK_W-1:0]  ld_blk,
  input  logic [NBLK_W-1:0] ld_nblk,
  input  logic              eng_done,
  input  logic              eng_ok,
  input  logic [CNT_W-1:0]  eng_nbytes,
  output logic              busy,
  output logic              eng_start,
  output logic              eng_op,
  output logic [BLK_W-1:0]  eng_blk,
  output logic [OFF_W-1:0]  eng_off,
  output logic [CNT_W-1:0]  eng_len,
  output logic [CNT_W-1:0]  eng_buf,
  output logic              done,
  output logic [CNT_W-1:0]  bytes_written,
  output bws_err_e          err_code,
  output logic              ev_erase_fail,
  output logic              ev_prog_fail,
  output logic              ev_blk_ok
);
  localparam logic [TRY_W-1:0] MAX_T   = TRY_W'(MAX_TRIES);
  localparam logic [TRY_W-1:0] TRY_TOP = '1;
  localparam logic [CNT_W-1:0] BLK_SZ  = CNT_W'(1) << BLK_SHIFT;

  function automatic logic [CNT_W-1:0] f_chunk(input logic [CNT_W-1:0] rem,
                                               input logic [BLK_SHIFT-1:0] lo);
    logic [CNT_W-1:0] room;
    room = BLK_SZ - CNT_W'(lo);
    return (rem < room) ? rem : room;
  endfunction

  function automatic logic [TRY_W-1:0] f_bump(input logic [TRY_W-1:0] t);
    return (t == TRY_TOP) ? t : t + TRY_W'(1);
  endfunction

  bws_state_e        state;
  logic [OFF_W-1:0]  cur_off;
  logic [CNT_W-1:0]  remain, written;
  logic [BLK_W-1:0]  blk;
  logic [NBLK_W-1:0] blk_left;
  logic [TRY_W-1:0]  e_tries, p_tries, e_next, p_next;

  assign busy          = (state != S_IDLE);
  assign eng_start     = (state == S_ERASE_GO) || (state == S_PROG_GO);
  assign eng_op        = (state == S_PROG_GO) || (state == S_PROG_WAIT);
  assign eng_blk       = blk;
  assign eng_off       = cur_off;
  assign eng_buf       = written;
  assign eng_len       = f_chunk(remain, cur_off[BLK_SHIFT-1:0]);
  assign ev_erase_fail = (state == S_ERASE_WAIT) && eng_done && !eng_ok;
  assign ev_prog_fail  = (state == S_PROG_WAIT) && eng_done && !eng_ok;
  assign ev_blk_ok     = (state == S_PROG_WAIT) && eng_done && eng_ok;
  assign e_next        = f_bump(e_tries);
  assign p_next        = f_bump(p_tries);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state         <= S_IDLE;
      cur_off       <= '0;
      remain        <= '0;
      written       <= '0;
      blk           <= '0;
      blk_left      <= '0;
      e_tries       <= '0;
      p_tries       <= '0;
      done          <= 1'b0;
      bytes_written <= '0;
      err_code      <= BWS_OK;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (finish_now) begin
            done          <= 1'b1;
            err_code      <= finish_err;
            bytes_written <= '0;
          end else if (start_job) begin
            cur_off  <= ld_off;
            remain   <= ld_cnt;
            written  <= '0;
            blk      <= ld_blk;
            blk_left <= ld_nblk;
            e_tries  <= '0;
            p_tries  <= '0;
            state    <= S_ERASE_GO;
          end
        end
        S_ERASE_GO: state <= S_ERASE_WAIT;
        S_ERASE_WAIT: begin
          if (eng_done) begin
            e_tries <= e_next;
            if (eng_ok) begin
              state <= S_PROG_GO;
            end else if (e_next >= MAX_T) begin
              state         <= S_IDLE;
              done          <= 1'b1;
              err_code      <= BWS_ERR_ERASE;
              bytes_written <= written;
            end else begin
              state <= S_ERASE_GO;
            end
          end
        end
        S_PROG_GO: state <= S_PROG_WAIT;
        S_PROG_WAIT: begin
          if (eng_done) begin
            if (eng_ok) begin
              cur_off  <= cur_off + OFF_W'(eng_nbytes);
              remain   <= remain - eng_nbytes;
              written  <= written + eng_nbytes;
              blk      <= blk + BLK_W'(1);
              blk_left <= blk_left - NBLK_W'(1);
              e_tries  <= '0;
              p_tries  <= '0;
              if (blk_left == NBLK_W'(1)) begin
                state         <= S_IDLE;
                done          <= 1'b1;
                err_code      <= BWS_OK;
                bytes_written <= written + eng_nbytes;
              end else begin
                state <= S_ERASE_GO;
              end
            end else begin
              p_tries <= p_next;
              if (p_next >= MAX_T) begin
                state         <= S_IDLE;
                done          <= 1'b1;
                err_code      <= BWS_ERR_PROG;
                bytes_written <= written;
              end else begin
                state <= S_ERASE_GO;
              end
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/blk_write_splitter.sv
module blk_write_splitter
  import bws_pkg::*;
#(
  parameter int OFF_W      = 24,
  parameter int CNT_W      = 24,
  parameter int BLK_SHIFT  = 16,
  parameter int SMALL_LOG2 = 20,
  parameter int LARGE_LOG2 = 22,
  parameter int MAX_TRIES  = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_valid,
  input  logic [1:0]                 cmd_code,
  output logic                       cmd_err,
  input  logic                       size_sel,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [OFF_W-1:0]           req_offset,
  input  logic [CNT_W-1:0]           req_count,
  output logic                       eng_start,
  output logic                       eng_op,
  output logic [OFF_W-BLK_SHIFT-1:0] eng_blk,
  output logic [OFF_W-1:0]           eng_off,
  output logic [CNT_W-1:0]           eng_len,
  output logic [CNT_W-1:0]           eng_buf,
  input  logic                       eng_done,
  input  logic                       eng_ok,
  input  logic [CNT_W-1:0]           eng_nbytes,
  output logic                       done,
  output logic [CNT_W-1:0]           bytes_written,
  output logic [2:0]                 err_code
);
  localparam int BLK_W  = OFF_W - BLK_SHIFT;
  localparam int NBLK_W = BLK_W + 1;

  logic              wr_en, low_en, busy;
  bws_err_e          chk_err, seq_err;
  logic              chk_zero;
  logic [CNT_W-1:0]  clip_cnt;
  logic [BLK_W-1:0]  first_blk;
  logic [NBLK_W-1:0] n_blk;
  logic              req_fire, finish_now, start_job;
  logic              ev_erase_fail, ev_prog_fail, ev_blk_ok;

  bws_enable_regs u_en (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .wr_en(wr_en), .low_en(low_en), .cmd_err(cmd_err)
  );

  bws_req_check #(
    .OFF_W(OFF_W), .CNT_W(CNT_W), .BLK_SHIFT(BLK_SHIFT),
    .SMALL_LOG2(SMALL_LOG2), .LARGE_LOG2(LARGE_LOG2),
    .BLK_W(BLK_W), .NBLK_W(NBLK_W)
  ) u_chk (
    .wr_en(wr_en), .low_en(low_en), .size_sel(size_sel),
    .offset(req_offset), .count(req_count),
    .chk_err(chk_err), .chk_zero(chk_zero), .clip_cnt(clip_cnt),
    .first_blk(first_blk), .n_blk(n_blk)
  );

  assign req_ready  = !busy;
  assign req_fire   = req_valid && !busy;
  assign finish_now = req_fire && ((chk_err != BWS_OK) || chk_zero);
  assign start_job  = req_fire && (chk_err == BWS_OK) && !chk_zero;

  bws_seq #(
    .OFF_W(OFF_W), .CNT_W(CNT_W), .BLK_SHIFT(BLK_SHIFT),
    .MAX_TRIES(MAX_TRIES), .BLK_W(BLK_W), .NBLK_W(NBLK_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start_job(start_job), .finish_now(finish_now), .finish_err(chk_err),
    .ld_off(req_offset), .ld_cnt(clip_cnt), .ld_blk(first_blk), .ld_nblk(n_blk),
    .eng_done(eng_done), .eng_ok(eng_ok), .eng_nbytes(eng_nbytes),
    .busy(busy), .eng_start(eng_start), .eng_op(eng_op), .eng_blk(eng_blk),
    .eng_off(eng_off), .eng_len(eng_len), .eng_buf(eng_buf),
    .done(done), .bytes_written(bytes_written), .err_code(seq_err),
    .ev_erase_fail(ev_erase_fail), .ev_prog_fail(ev_prog_fail),
    .ev_blk_ok(ev_blk_ok)
  );

  assign err_code = seq_err;
endmodule

// File: rtl/bws_chk.sv
module bws_chk #(
  parameter int MAX_TRIES = 10,
  parameter int CNT_W     = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [1:0]       cmd_code,
  input logic             cmd_err,
  input logic             req_valid,
  input logic             req_ready,
  input logic [CNT_W-1:0] req_count,
  input logic             eng_start,
  input logic             eng_op,
  input logic             eng_done,
  input logic             done,
  input logic             ev_erase_fail,
  input logic             ev_prog_fail,
  input logic             ev_blk_ok
);
  localparam logic [7:0] LIM = 8'(MAX_TRIES - 1);

  logic       outstanding, erase_ok_seen;
  logic [7:0] e_cnt, p_cnt;
  logic       accept;

  assign accept = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outstanding   <= 1'b0;
      erase_ok_seen <= 1'b0;
      e_cnt         <= '0;
      p_cnt         <= '0;
    end else begin
      if (eng_start) outstanding <= 1'b1;
      else if (eng_done) outstanding <= 1'b0;
      if (eng_start && eng_op) erase_ok_seen <= 1'b0;
      else if (eng_done && !eng_op && !ev_erase_fail) erase_ok_seen <= 1'b1;
      if (accept || ev_blk_ok) begin
        e_cnt <= '0;
        p_cnt <= '0;
      end else begin
        if (eng_done && !eng_op && e_cnt != 8'hFF) e_cnt <= e_cnt + 8'd1;
        if (ev_prog_fail && p_cnt != 8'hFF) p_cnt <= p_cnt + 8'd1;
      end
    end
  end

  p_cmd_err_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == 2'b11) |=> cmd_err);
  p_cmd_err_src_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> $past(cmd_valid && cmd_code == 2'b11));
  p_fast_finish_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_count == '0) |=> done);
  p_prog_after_erase_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_start && eng_op) |-> erase_ok_seen);
  p_erase_limit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_erase_fail && e_cnt >= LIM) |=> done);
  p_erase_retry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_erase_fail && e_cnt < LIM) |=> !done);
  p_prog_limit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_prog_fail && p_cnt >= LIM) |=> done);
  p_prog_retry_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_prog_fail && p_cnt < LIM) |=> !done);
  p_start_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);
  p_one_job_r11: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> !outstanding);
  p_start_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> !req_ready);
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind blk_write_splitter bws_chk #(.MAX_TRIES(MAX_TRIES), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
  .cmd_err(cmd_err), .req_valid(req_valid), .req_ready(req_ready),
  .req_count(req_count), .eng_start(eng_start), .eng_op(eng_op),
  .eng_done(eng_done), .done(done), .ev_erase_fail(ev_erase_fail),
  .ev_prog_fail(ev_prog_fail), .ev_blk_ok(ev_blk_ok)
);

// File: tb/blk_write_splitter_tb_top.sv
module blk_write_splitter_tb_top;
  localparam int OFF_W = 24;
  localparam int CNT_W = 24;
  localparam int BLK_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cmd_valid = 1'b0;
  logic [1:0]       cmd_code = 2'd0;
  logic             cmd_err;
  logic             size_sel = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [OFF_W-1:0] req_offset = '0;
  logic [CNT_W-1:0] req_count = '0;
  logic             eng_start, eng_op;
  logic [BLK_W-1:0] eng_blk;
  logic [OFF_W-1:0] eng_off;
  logic [CNT_W-1:0] eng_len, eng_buf;
  logic             eng_done = 1'b0;
  logic             eng_ok = 1'b0;
  logic [CNT_W-1:0] eng_nbytes = '0;
  logic             done;
  logic [CNT_W-1:0] bytes_written;
  logic [2:0]       err_code;

  int checks = 0;
  int errors = 0;
  bit m_wr = 0, m_low = 0;

  int q_op[$], q_blk[$], q_off[$], q_len[$], q_buf[$];
  int exp_err, exp_bytes;

  always #10 clk = ~clk;

  blk_write_splitter dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_err(cmd_err), .size_sel(size_sel), .req_valid(req_valid),
    .req_ready(req_ready), .req_offset(req_offset), .req_count(req_count),
    .eng_start(eng_start), .eng_op(eng_op), .eng_blk(eng_blk),
    .eng_off(eng_off), .eng_len(eng_len), .eng_buf(eng_buf),
    .eng_done(eng_done), .eng_ok(eng_ok), .eng_nbytes(eng_nbytes),
    .done(done), .bytes_written(bytes_written), .err_code(err_code)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // behavioural reference: expected job list and result for one request
  task automatic build(input int off, input int cnt, input bit big,
                       input int efail, input int pfail, input int fblk);
    int cap, c, p, w, b, nb, len, ec, pc, ef, pf;
    bit stop, blk_fin;
    q_op.delete(); q_blk.delete(); q_off.delete(); q_len.delete(); q_buf.delete();
    exp_err = 0; exp_bytes = 0;
    cap = big ? 4194304 : 1048576;
    if (!m_wr) exp_err = 1;
    else if (off < 65536 && !m_low) exp_err = 2;
    else if (cnt == 0) exp_err = 0;
    else if (off >= cap) exp_err = 3;
    else begin
      c = (cnt > cap - off) ? cap - off : cnt;
      p = off; w = 0; b = off / 65536;
      nb = (off + c) / 65536 - b + 1;
      if ((off + c) % 65536 == 0) nb--;
      ef = efail; pf = pfail; stop = 0;
      for (int k = 0; k < nb && !stop; k++) begin
        ec = 0; pc = 0; blk_fin = 0;
        len = (c - w < 65536 - p % 65536) ? c - w : 65536 - p % 65536;
        while (!blk_fin && !stop) begin
          q_op.push_back(0); q_blk.push_back(b); q_off.push_back(p);
          q_len.push_back(len); q_buf.push_back(w);
          ec++;
          if (b == fblk && ef > 0) begin
            ef--;
            if (ec >= 10) begin exp_err = 4; stop = 1; end
          end else begin
            q_op.push_back(1); q_blk.push_back(b); q_off.push_back(p);
            q_len.push_back(len); q_buf.push_back(w);
            pc++;
            if (b == fblk && pf > 0) begin
              pf--;
              if (pc >= 10) begin exp_err = 5; stop = 1; end
            end else blk_fin = 1;
          end
        end
        if (!stop) begin p += len; w += len; b++; end
      end
      exp_bytes = w;
    end
  endtask

  task automatic send_cmd(input int code);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = 2'(code);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(cmd_err == (code == 3), "R1 cmd_err pulse", int'(cmd_err), int'(code == 3));
    @(negedge clk);
    chk(cmd_err == 1'b0, "R1 cmd_err single cycle", int'(cmd_err), 0);
    case (code)
      0: begin m_wr = 0; m_low = 0; end
      1: m_wr = 1;
      2: m_low = 1;
      default: begin m_wr = 0; m_low = 0; end
    endcase
  endtask

  task automatic do_req(input int off, input int cnt, input bit big,
                        input int efail, input int pfail, input int fblk,
                        input string tag);
    int cyc, pend, ef, pf, rn, e_op, e_blk, e_off, e_len, e_buf;
    bit rok, prev_start, fin;
    build(off, cnt, big, efail, pfail, fblk);
    ef = efail; pf = pfail; pend = 0; prev_start = 0; fin = 0; cyc = 0;
    rok = 0; rn = 0;
    @(negedge clk);
    size_sel = big; req_offset = OFF_W'(off); req_count = CNT_W'(cnt);
    chk(req_ready == 1'b1, {tag, " R11 ready when idle"}, int'(req_ready), 1);
    req_valid = 1'b1;
    while (!fin && cyc < 20000) begin
      @(negedge clk);
      req_valid = 1'b0;
      cyc++;
      eng_done = 1'b0;
      if (done) begin
        fin = 1;
        chk(int'(err_code) == exp_err, {tag, " err_code"}, int'(err_code), exp_err);
        chk(int'(bytes_written) == exp_bytes, {tag, " R12 bytes_written"},
            int'(bytes_written), exp_bytes);
        chk(q_op.size() == 0, {tag, " R7 all jobs issued"}, q_op.size(), 0);
        if (exp_err != 0 && exp_err < 4 || (exp_err == 0 && exp_bytes == 0))
          chk(cyc == 1, {tag, " R2 R4 early finish latency"}, cyc, 1);
      end else begin
        if (!req_ready == 1'b0)
          chk(0, {tag, " R11 ready low while busy"}, int'(req_ready), 0);
        if (eng_start) begin
          chk(!prev_start && pend == 0, {tag, " R11 start pulse/outstanding"},
              int'(prev_start), 0);
          if (q_op.size() == 0) begin
            chk(0, {tag, " R7 unexpected job"}, int'(eng_blk), -1);
          end else begin
            e_op = q_op.pop_front(); e_blk = q_blk.pop_front();
            e_off = q_off.pop_front(); e_len = q_len.pop_front();
            e_buf = q_buf.pop_front();
            chk(int'(eng_op) == e_op && int'(eng_blk) == e_blk,
                {tag, " R7 op/blk"}, int'(eng_op) * 256 + int'(eng_blk), e_op * 256 + e_blk);
            chk(int'(eng_off) == e_off && int'(eng_buf) == e_buf,
                {tag, " R8 off/buf"}, int'(eng_off), e_off);
            chk(int'(eng_len) == e_len, {tag, " R8 len"}, int'(eng_len), e_len);
            rn = e_len; rok = 1;
            if (int'(eng_blk) == fblk) begin
              if (!eng_op && ef > 0) begin rok = 0; ef--; end
              else if (eng_op && pf > 0) begin rok = 0; pf--; end
            end
          end
          pend = 3;
        end else if (pend > 0) begin
          pend--;
          if (pend == 0) begin
            eng_done = 1'b1; eng_ok = rok; eng_nbytes = CNT_W'(rn);
          end
        end
      end
      prev_start = eng_start;
    end
    chk(fin, {tag, " completion"}, int'(fin), 1);
    @(negedge clk);
    chk(done == 1'b0, {tag, " R12 done single cycle"}, int'(done), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && done == 1'b0 && eng_start == 1'b0 && cmd_err == 1'b0,
        "R11 R12 reset state", int'({req_ready, done, eng_start, cmd_err}), 8);

    do_req(32'h20000, 16, 0, 0, 0, -1, "R2 disabled");
    send_cmd(1);
    do_req(32'h100, 10, 0, 0, 0, -1, "R3 low region");
    send_cmd(2);
    send_cmd(0);
    send_cmd(1);
    do_req(32'h100, 10, 0, 0, 0, -1, "R1 lock clears low enable R3");
    send_cmd(2);
    do_req(32'h100, 0, 0, 0, 0, -1, "R4 zero count");
    do_req(32'h100000, 5, 0, 0, 0, -1, "R5 beyond 1MiB");
    do_req(32'h100000, 16, 1, 0, 0, -1, "R5 inside 4MiB");
    do_req(32'h400000, 16, 1, 0, 0, -1, "R5 beyond 4MiB");
    do_req(32'h100, 32'h30, 0, 0, 0, -1, "R7 low region single");
    do_req(32'h1FFF0, 32'h20, 0, 0, 0, -1, "R7 R8 straddle");
    do_req(32'h20000, 32'h10000, 0, 0, 0, -1, "R7 exact boundary");
    do_req(32'h2FFF0, 32'h20010, 0, 0, 0, -1, "R7 R8 three blocks");
    do_req(32'hF8000, 32'h20000, 0, 0, 0, -1, "R6 clip 1MiB");
    do_req(32'h3F0000, 32'h30000, 1, 0, 0, -1, "R6 clip 4MiB");
    do_req(32'h2FFF0, 32'h20, 0, 3, 0, 3, "R9 erase retry ok");
    do_req(32'h2FFF0, 32'h20, 0, 10, 0, 3, "R9 erase limit");
    do_req(32'h2FFF0, 32'h20, 0, 0, 2, 3, "R10 program retry ok");
    do_req(32'h2FFF0, 32'h20, 0, 0, 10, 2, "R10 program limit");
    do_req(32'h2FFF0, 32'h20, 0, 0, 9, 3, "R10 nine program fails");
    send_cmd(3);
    do_req(32'h20000, 16, 0, 0, 0, -1, "R1 invalid clears enables R2");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule